// File: doc/BRIEF.md
# Masked Bank Decoder with Read Turnaround

This block sits between a bus master and twelve external memory banks. Each bank has a base register and an option register. An incoming access is compared against every bank. The upper 17 address bits are used, and each bit takes part in the compare only where that bank's mask bit is set. The lowest-numbered matching bank is selected. The block then drives that bank's chip-select for the access and, unless the bank disables it, a data-buffer enable strobe.

A bank may refuse bursts. In that case a four-beat burst request is carried out as four single accesses, with a dead cycle between them. The address steps by one beat size for each beat, in both the burst case and the split case. After a read, a per-bank field inserts 0, 1, 4 or 8 idle cycles before the next request is accepted. An access that hits no bank raises a one-cycle unmapped flag and selects nothing. A simple word-addressed register port programs and reads back all banks. It can be used at any time, including while an access is in flight.

Top module: `membank_decoder`

## Requirements
- R1: After reset, every register reads zero. `req_ready` is 1 and `cs`, `buf_en` and `unmapped` are 0. Because every mask is fully clear, any address then selects bank 0.
- R2: An address selects bank n when `addr[31:15]` equals bank n's base bits in every position where the mask is 1. Positions where the mask is 0 are ignored. A non-contiguous mask therefore lets one bank answer in several disjoint regions.
- R3: When several banks match, only the lowest-numbered one gets its `cs` bit. `cs` is never more than one-hot.
- R4: An accepted request that matches no bank leaves `cs` at zero. It pulses `unmapped` high for exactly the one cycle after acceptance, and `req_ready` stays 1.
- R5: `buf_en` is high in every beat cycle of a bank whose buffer-disable bit (option bit 12) is 0. It is never high for a bank whose buffer-disable bit is 1.
- R6: With burst-inhibit (option bit 8) at 0, a burst request gives four consecutive beat cycles with `cs` held. `beat_addr` steps by 8 each beat, and `beat_last` is set on the fourth beat only. A non-burst request gives one beat cycle, marked last.
- R7: With burst-inhibit at 1, a burst request gives four single beats, each followed by one cycle with `cs` low. The addresses step by 8.
- R8: Option bits 2:1 select the idle cycles after a read: 00 gives 0, 01 gives 1, 10 gives 4 and 11 gives 8. During these cycles `req_ready` is 0 and `cs` is 0.
- R9: A write never inserts idle cycles, whatever the hold field holds. `req_ready` returns the cycle after the last beat.
- R10: Bank n's base is at word offset 2n, in bits 31:15. Its option register is at 2n+1, with mask in 31:15, buffer-disable in 12, burst-inhibit in 8 and hold in 2:1. Every other bit, and every offset of 2×12 or above, reads zero.
- R11: A mask may be rewritten during an access. The access in flight keeps its bank, beats and strobes, and the next request decodes with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Access request, taken when `req_ready` is 1 |
| req_addr | input | 32 | Access start address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 1 | 1 for a four-beat burst |
| req_ready | output | 1 | Block idle and able to take a request |
| cs | output | 12 | One-hot bank chip-select, active high |
| buf_en | output | 1 | Data-buffer enable strobe |
| beat_addr | output | 32 | Address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the access |
| unmapped | output | 1 | One-cycle pulse: accepted request hit no bank |

## Verification
The bench targets overlapping banks. A decoder with the priority reversed would select the higher bank there. It also uses a mask with holes, which a range-style compare would treat as a contiguous block and so answer in the wrong places. Every hold code is exercised on reads, and the same banks are then written to. Swapped hold codes show up as an off-by-several idle count, and a design that also holds after writes shows up as an extra idle count. The split burst is checked cycle by cycle for its dead cycles and address steps. A mask is rewritten in the middle of a burst, which catches a design that re-decodes during an access or keeps a stale decode for the next request.

// File: rtl/mbd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, option-register layout and sequencer states.
// Assumes a 32-bit register word and a 17-bit upper-address compare field.
package mbd_pkg;

    localparam int REG_W      = 32;
    localparam int MASK_W     = 17;
    localparam int MASK_LSB   = 15;
    localparam int HOLD_CNT_W = 4;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              bctl_dis;
        logic              burst_inh;
        logic [1:0]        hold;
    } bank_opt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_GAP,
        ST_HOLD
    } seq_state_t;

    // Map the 2-bit hold code to its idle-cycle count.
    function automatic logic [HOLD_CNT_W-1:0] hold_cycles(input logic [1:0] code);
        case (code)
            2'b00:   return HOLD_CNT_W'(0);
            2'b01:   return HOLD_CNT_W'(1);
            2'b10:   return HOLD_CNT_W'(4);
            default: return HOLD_CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/mbd_regs.sv
`timescale 1ns/1ps
// Bank register file: one base and one option register per bank.
// Even offsets hold bases and odd offsets hold options. Reserved bits are
// dropped on write and read as zero. Reads are combinational.
module mbd_regs
    import mbd_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int BANK_W    = 4,
    parameter int CFG_AW    = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_wr,
    input  logic [CFG_AW-1:0]                  cfg_addr,
    input  logic [REG_W-1:0]                   cfg_wdata,
    output logic [REG_W-1:0]                   cfg_rdata,
    output logic [NUM_BANKS-1:0][MASK_W-1:0]   bases,
    output bank_opt_t [NUM_BANKS-1:0]          opts
);

    logic [BANK_W-1:0] rd_idx;
    logic              unused_resv;

    assign unused_resv = ^{cfg_wdata[14:13], cfg_wdata[11:9], cfg_wdata[7:3], cfg_wdata[0]};
    assign rd_idx      = cfg_addr[CFG_AW-1:1];

    // Store base and option fields for the bank addressed by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bases <= '0;
            opts  <= '0;
        end else if (cfg_wr) begin
            for (int n = 0; n < NUM_BANKS; n++) begin
                if (cfg_addr == CFG_AW'(2*n)) begin
                    bases[n] <= cfg_wdata[REG_W-1:MASK_LSB];
                end
                if (cfg_addr == CFG_AW'(2*n+1)) begin
                    opts[n].mask      <= cfg_wdata[REG_W-1:MASK_LSB];
                    opts[n].bctl_dis  <= cfg_wdata[12];
                    opts[n].burst_inh <= cfg_wdata[8];
                    opts[n].hold      <= cfg_wdata[2:1];
                end
            end
        end
    end

    // Return the addressed register with reserved positions as zero.
    always_comb begin
        cfg_rdata = '0;
        if (int'(rd_idx) < NUM_BANKS) begin
            if (cfg_addr[0]) begin
                cfg_rdata = {opts[rd_idx].mask, 2'b00, opts[rd_idx].bctl_dis, 3'b000,
                             opts[rd_idx].burst_inh, 5'b00000, opts[rd_idx].hold, 1'b0};
            end else begin
                cfg_rdata = {bases[rd_idx], {MASK_LSB{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/mbd_match.sv
`timescale 1ns/1ps
// Address matcher: masked compare of the upper address bits against every
// bank base, followed by a lowest-index-wins priority pick. Purely combinational.
module mbd_match
    import mbd_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int BANK_W    = 4
) (
    input  logic [MASK_W-1:0]                  addr_hi,
    input  logic [NUM_BANKS-1:0][MASK_W-1:0]   bases,
    input  bank_opt_t [NUM_BANKS-1:0]          opts,
    output logic                               hit,
    output logic [BANK_W-1:0]                  hit_idx
);

    logic [NUM_BANKS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
        assign hit_vec[g] = ((addr_hi ^ bases[g]) & opts[g].mask) == '0;
    end

    // Pick the lowest-numbered matching bank.
    always_comb begin
        hit_idx = '0;
        for (int n = NUM_BANKS - 1; n >= 0; n--) begin
            if (hit_vec[n]) hit_idx = BANK_W'(n);
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/mbd_seq.sv
`timescale 1ns/1ps
// Access sequencer: takes one request while idle and runs its beats.
// A split burst gets a dead cycle between beats. A read is followed by its
// hold window. The bank options are latched when the request is taken.
module mbd_seq
    import mbd_pkg::*;
#(
    parameter int NUM_BANKS   = 12,
    parameter int BANK_W      = 4,
    parameter int ADDR_W      = 32,
    parameter int BEAT_BYTES  = 8,
    parameter int BURST_BEATS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    input  logic                   req_burst,
    input  logic                   hit,
    input  logic [BANK_W-1:0]      hit_idx,
    input  logic                   hit_bctl_dis,
    input  logic                   hit_burst_inh,
    input  logic [1:0]             hit_hold,
    output logic                   req_ready,
    output logic [NUM_BANKS-1:0]   cs,
    output logic                   buf_en,
    output logic [ADDR_W-1:0]      beat_addr,
    output logic                   beat_last,
    output logic                   unmapped
);

    localparam int BEAT_CNT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    seq_state_t              state_q;
    logic [BANK_W-1:0]       bank_q;
    logic [ADDR_W-1:0]       addr_q;
    logic                    wr_q;
    logic                    inh_q;
    logic                    bctl_q;
    logic [BEAT_CNT_W-1:0]   left_q;
    logic [HOLD_CNT_W-1:0]   cnt_q;
    logic                    unm_q;

    // Advance the access state machine and latch request details on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            inh_q   <= 1'b0;
            bctl_q  <= 1'b0;
            left_q  <= '0;
            cnt_q   <= '0;
            unm_q   <= 1'b0;
        end else begin
            unm_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            bank_q  <= hit_idx;
                            addr_q  <= req_addr;
                            wr_q    <= req_write;
                            inh_q   <= hit_burst_inh;
                            bctl_q  <= hit_bctl_dis;
                            left_q  <= req_burst ? BEAT_CNT_W'(BURST_BEATS - 1) : '0;
                            cnt_q   <= hold_cycles(hit_hold);
                            state_q <= ST_BEAT;
                        end else begin
                            unm_q <= 1'b1;
                        end
                    end
                end
                ST_BEAT: begin
                    if (left_q == '0) begin
                        if (!wr_q && cnt_q != '0) state_q <= ST_HOLD;
                        else                      state_q <= ST_IDLE;
                    end else begin
                        left_q  <= left_q - 1'b1;
                        addr_q  <= addr_q + ADDR_W'(BEAT_BYTES);
                        state_q <= inh_q ? ST_GAP : ST_BEAT;
                    end
                end
                ST_GAP: begin
                    state_q <= ST_BEAT;
                end
                ST_HOLD: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == HOLD_CNT_W'(1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the bank select from the latched bank index during beat cycles.
    always_comb begin
        cs = '0;
        if (state_q == ST_BEAT) cs[bank_q] = 1'b1;
    end

    assign req_ready = (state_q == ST_IDLE);
    assign buf_en    = (state_q == ST_BEAT) && !bctl_q;
    assign beat_addr = addr_q;
    assign beat_last = (state_q == ST_BEAT) && (left_q == '0);
    assign unmapped  = unm_q;

endmodule

// File: rtl/membank_decoder.sv
`timescale 1ns/1ps
// Top of the masked bank decoder: register file, address matcher and
// access sequencer. Assumes ADDR_W >= 17 so the compare field is the upper
// 17 address bits.
module membank_decoder
    import mbd_pkg::*;
#(
    parameter int NUM_BANKS   = 12,
    parameter int ADDR_W      = 32,
    parameter int BEAT_BYTES  = 8,
    parameter int BURST_BEATS = 4,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int CFG_AW     = BANK_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic [REG_W-1:0]       cfg_rdata,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   req_write,
    input  logic                   req_burst,
    output logic                   req_ready,
    output logic [NUM_BANKS-1:0]   cs,
    output logic                   buf_en,
    output logic [ADDR_W-1:0]      beat_addr,
    output logic                   beat_last,
    output logic                   unmapped
);

    logic [NUM_BANKS-1:0][MASK_W-1:0] bases;
    bank_opt_t [NUM_BANKS-1:0]        opts;
    logic                             hit;
    logic [BANK_W-1:0]                hit_idx;
    bank_opt_t                        hit_opt;

    mbd_regs #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .CFG_AW    (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bases     (bases),
        .opts      (opts)
    );

    mbd_match #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_match (
        .addr_hi   (req_addr[ADDR_W-1 -: MASK_W]),
        .bases     (bases),
        .opts      (opts),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    assign hit_opt = opts[hit_idx];

    mbd_seq #(
        .NUM_BANKS   (NUM_BANKS),
        .BANK_W      (BANK_W),
        .ADDR_W      (ADDR_W),
        .BEAT_BYTES  (BEAT_BYTES),
        .BURST_BEATS (BURST_BEATS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_burst     (req_burst),
        .hit           (hit),
        .hit_idx       (hit_idx),
        .hit_bctl_dis  (hit_opt.bctl_dis),
        .hit_burst_inh (hit_opt.burst_inh),
        .hit_hold      (hit_opt.hold),
        .req_ready     (req_ready),
        .cs            (cs),
        .buf_en        (buf_en),
        .beat_addr     (beat_addr),
        .beat_last     (beat_last),
        .unmapped      (unmapped)
    );

endmodule

// File: rtl/membank_decoder_chk.sv
`timescale 1ns/1ps
// Checker for the bank decoder's port-level rules, bound into the top.
// Uses only the top's outputs and reset.
module membank_decoder_chk #(
    parameter int NUM_BANKS  = 12,
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic [NUM_BANKS-1:0] cs,
    input logic                 buf_en,
    input logic [ADDR_W-1:0]    beat_addr,
    input logic                 beat_last,
    input logic                 unmapped
);

    // R3: at most one bank selected
    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));

    // R4: an unmapped pulse selects nothing and leaves the block idle
    a_r4_unmapped_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (cs == '0 && req_ready));

    // R5: buffer strobe only inside a selected beat
    a_r5_bufen_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> (cs != '0));

    // R6: back-to-back beat cycles step the address by one beat
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cs != '0 && $past(cs) != '0) |-> (beat_addr == $past(beat_addr) + ADDR_W'(BEAT_BYTES)));

    // R8: while ready no bank is selected (hold and idle cycles are quiet)
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs == '0 && !beat_last));

endmodule

bind membank_decoder membank_decoder_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES)
) u_membank_decoder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cs        (cs),
    .buf_en    (buf_en),
    .beat_addr (beat_addr),
    .beat_last (beat_last),
    .unmapped  (unmapped)
);

// File: tb/membank_decoder_bench.sv
`timescale 1ns/1ps
// Directed bench for the bank decoder: one task per scenario.
module membank_decoder_bench;

    localparam int NB = 12;
    localparam int TR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic        req_ready;
    logic [NB-1:0] cs;
    logic        buf_en;
    logic [31:0] beat_addr;
    logic        beat_last;
    logic        unmapped;

    int n_chk  = 0;
    int n_fail = 0;

    logic [NB-1:0] cs_l  [TR];
    logic [31:0]   adr_l [TR];
    logic          buf_l [TR];
    logic          lst_l [TR];
    logic          rdy_l [TR];
    logic          unm_l [TR];

    membank_decoder u_membank_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
        .req_ready(req_ready), .cs(cs), .buf_en(buf_en), .beat_addr(beat_addr),
        .beat_last(beat_last), .unmapped(unmapped)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_opt(input logic [31:0] mask, input bit bctl, input bit inh, input logic [1:0] hold);
        return (mask & 32'hFFFF_8000) | (32'(bctl) << 12) | (32'(inh) << 8) | (32'(hold) << 1);
    endfunction

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Issue one request and record TR cycles of outputs; optional mid-access register write.
    task automatic run_access(input logic [31:0] a, input logic wr, input logic burst,
                              input logic mid, input logic [4:0] mid_a, input logic [31:0] mid_d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_burst = burst;
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int k = 0; k < TR; k++) begin
            @(negedge clk);
            cs_l[k] = cs; adr_l[k] = beat_addr; buf_l[k] = buf_en;
            lst_l[k] = beat_last; rdy_l[k] = req_ready; unm_l[k] = unmapped;
            if (mid && k == 1) begin cfg_wr = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d; end
            if (mid && k == 2) cfg_wr = 1'b0;
        end
    endtask

    // Compare a recorded trace against the expected beat pattern.
    task automatic check_trace(input string req, input int bank, input logic [31:0] a,
                               input bit burst, input bit inh, input bit buf_on, input int hold);
        int span = !burst ? 1 : (inh ? 7 : 4);
        int step = (burst && inh) ? 2 : 1;
        for (int k = 0; k < TR; k++) begin
            bit active = (k < span) && (k % step == 0);
            chk(req, $sformatf("cs[%0d]", k), 64'(cs_l[k]), active ? 64'(1) << bank : 64'(0));
            chk(req, $sformatf("buf_en[%0d]", k), 64'(buf_l[k]), 64'(active && buf_on));
            chk(req, $sformatf("ready[%0d]", k), 64'(rdy_l[k]), 64'(k >= span + hold));
            if (active) begin
                chk(req, $sformatf("addr[%0d]", k), 64'(adr_l[k]), 64'(a + 32'(8 * (k / step))));
                chk(req, $sformatf("last[%0d]", k), 64'(lst_l[k]), 64'(k == span - 1));
            end
        end
        chk(req, "unmapped", 64'(unm_l[0]), 64'(0));
    endtask

    task automatic check_unmapped(input string req);
        chk(req, "unmapped pulse", 64'(unm_l[0]), 64'(1));
        chk(req, "unmapped drop", 64'(unm_l[1]), 64'(0));
        for (int k = 0; k < 4; k++) begin
            chk(req, "cs idle", 64'(cs_l[k]), 64'(0));
            chk(req, "ready", 64'(rdy_l[k]), 64'(1));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "ready", 64'(req_ready), 64'(1));
        chk("R1", "cs", 64'(cs), 64'(0));
        chk("R1", "unmapped", 64'(unmapped), 64'(0));
        chk("R1", "buf_en", 64'(buf_en), 64'(0));
        rd_reg(5'd0, d);  chk("R1", "base0", 64'(d), 64'(0));
        rd_reg(5'd23, d); chk("R1", "opt11", 64'(d), 64'(0));
        run_access(32'h1234_5678, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R1", 0, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr_reg(5'd3, 32'hFFFF_FFFF);
        rd_reg(5'd3, d); chk("R10", "opt1 fields", 64'(d), 64'hFFFF_9106);
        wr_reg(5'd2, 32'hFFFF_FFFF);
        rd_reg(5'd2, d); chk("R10", "base1 field", 64'(d), 64'hFFFF_8000);
        rd_reg(5'd24, d); chk("R10", "offset 24", 64'(d), 64'(0));
        rd_reg(5'd31, d); chk("R10", "offset 31", 64'(d), 64'(0));
    endtask

    task automatic program_banks();
        wr_reg(5'd0, 32'h0000_0000); wr_reg(5'd1, mk_opt(32'hFFFF_FFFF, 0, 0, 2'b00));
        wr_reg(5'd2, 32'h1000_0000); wr_reg(5'd3, mk_opt(32'hF000_8000, 0, 0, 2'b00));
        wr_reg(5'd4, 32'h2000_0000); wr_reg(5'd5, mk_opt(32'hFFFF_FFFF, 1, 1, 2'b00));
        wr_reg(5'd6, 32'h3000_0000); wr_reg(5'd7, mk_opt(32'hFFFF_FFFF, 0, 0, 2'b01));
        wr_reg(5'd8, 32'h4000_0000); wr_reg(5'd9, mk_opt(32'hFFFF_FFFF, 0, 0, 2'b10));
        wr_reg(5'd10, 32'h5000_0000); wr_reg(5'd11, mk_opt(32'hFFFF_FFFF, 0, 0, 2'b11));
        wr_reg(5'd12, 32'h6000_0000); wr_reg(5'd13, mk_opt(32'hFFFF_FFFF, 0, 0, 2'b00));
        wr_reg(5'd14, 32'h6000_0000); wr_reg(5'd15, mk_opt(32'hF000_0000, 0, 0, 2'b00));
        for (int n = 8; n < NB; n++) begin
            wr_reg(5'(2 * n), 32'hF000_0000);
            wr_reg(5'(2 * n + 1), mk_opt(32'hFFFF_FFFF, 0, 0, 2'b00));
        end
    endtask

    task automatic t_mask();
        run_access(32'h1000_0010, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R2 region a", 1, 32'h1000_0010, 1'b0, 1'b0, 1'b1, 0);
        run_access(32'h1234_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R2 region b", 1, 32'h1234_0000, 1'b0, 1'b0, 1'b1, 0);
        run_access(32'h1FFF_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R2 region c", 1, 32'h1FFF_0000, 1'b0, 1'b0, 1'b1, 0);
        run_access(32'h1000_8000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_unmapped("R2 hole");
    endtask

    task automatic t_priority();
        run_access(32'h6000_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R3 overlap", 6, 32'h6000_0000, 1'b0, 1'b0, 1'b1, 0);
        run_access(32'h6800_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R3 single", 7, 32'h6800_0000, 1'b0, 1'b0, 1'b1, 0);
    endtask

    task automatic t_unmapped();
        run_access(32'h9000_0000, 1'b0, 1'b1, 1'b0, '0, '0);
        check_unmapped("R4");
    endtask

    task automatic t_burst();
        run_access(32'h0000_0040, 1'b0, 1'b1, 1'b0, '0, '0);
        check_trace("R6", 0, 32'h0000_0040, 1'b1, 1'b0, 1'b1, 0);
    endtask

    task automatic t_inhibit();
        run_access(32'h2000_0100, 1'b0, 1'b1, 1'b0, '0, '0);
        check_trace("R7 R5", 2, 32'h2000_0100, 1'b1, 1'b1, 1'b0, 0);
        run_access(32'h2000_0000, 1'b1, 1'b0, 1'b0, '0, '0);
        check_trace("R5 write", 2, 32'h2000_0000, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_hold();
        run_access(32'h3000_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R8 code01", 3, 32'h3000_0000, 1'b0, 1'b0, 1'b1, 1);
        run_access(32'h4000_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R8 code10", 4, 32'h4000_0000, 1'b0, 1'b0, 1'b1, 4);
        run_access(32'h5000_0000, 1'b0, 1'b1, 1'b0, '0, '0);
        check_trace("R8 code11", 5, 32'h5000_0000, 1'b1, 1'b0, 1'b1, 8);
    endtask

    task automatic t_write_hold();
        run_access(32'h5000_0020, 1'b1, 1'b0, 1'b0, '0, '0);
        check_trace("R9 single", 5, 32'h5000_0020, 1'b0, 1'b0, 1'b1, 0);
        run_access(32'h4000_0000, 1'b1, 1'b1, 1'b0, '0, '0);
        check_trace("R9 burst", 4, 32'h4000_0000, 1'b1, 1'b0, 1'b1, 0);
    endtask

    task automatic t_live_mask();
        logic [31:0] d;
        run_access(32'h0100_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_unmapped("R11 before");
        run_access(32'h0000_0000, 1'b0, 1'b1, 1'b1, 5'd1, mk_opt(32'h8000_0000, 0, 0, 2'b00));
        check_trace("R11 in flight", 0, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 0);
        rd_reg(5'd1, d); chk("R11", "new mask", 64'(d), 64'h8000_0000);
        run_access(32'h0100_0000, 1'b0, 1'b0, 1'b0, '0, '0);
        check_trace("R11 after", 0, 32'h0100_0000, 1'b0, 1'b0, 1'b1, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        program_banks();
        t_mask();
        t_priority();
        t_unmapped();
        t_burst();
        t_inhibit();
        t_hold();
        t_write_hold();
        t_live_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule